// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block caches page-table entries so that a virtual page number can be turned into a physical frame number with a single lookup. Any entry may hold any page, so the buffer is fully associative. Each entry also records the address space (process id) that owns it. Mappings that belong to several processes can therefore stay resident together, and a process switch does not have to empty the buffer. A lookup presents a virtual address, the current process id and a read/write flag. One clock later the block reports a hit or a miss, the physical address and a protection fault flag.

An outside agent walks the page table and services faults. After a miss it writes the missing mapping through the refill port. A refill first takes a free slot. When no slot is free it evicts a resident entry chosen by a rotating pointer. A flush command clears either every entry or only the entries of one process. A build option turns process tagging off for address spaces without ids: the tag is then ignored and every flush empties the whole buffer.

Top module: `ptag_tlb`

## Requirements
- R1: A lookup with `lk_valid` high in cycle N reports in cycle N+1 with `lk_done` high. A hit requires a valid entry with an equal virtual page number (bits above OFS_W of `lk_vaddr`) and an equal process id. On a hit, `lk_paddr` is the stored frame number concatenated above the unchanged low OFS_W address bits. On a miss, `lk_paddr` is zero.
- R2: With tagging on, two entries with the same page number and different process ids coexist. Each one is reached only with its own id, and a lookup with an id that has no entry misses.
- R3: With PID_EN=0 the process id takes no part in matching or refill placement. Every flush clears all entries, whatever the value of `fl_all`.
- R4: At most one entry matches a given tag. A refill of a page already present (same page and id) overwrites that entry in place, and all other entries stay intact.
- R5: A refill of an absent page goes into the lowest-numbered invalid entry whenever one exists, and no valid entry is evicted.
- R6: A write (`lk_write`=1) to an entry whose write permission is clear reports `lk_fault`=1 with `lk_hit`=0 and a zero address, and leaves the entry's referenced and modified bits unchanged. A read of that entry hits.
- R7: A flush with `fl_all`=1 invalidates every entry. With `fl_all`=0 it invalidates only the entries whose process id equals `fl_pid`.
- R8: On a hit, `lk_ref_prev` and `lk_mod_prev` show the entry's referenced and modified bits before the access. A hit sets referenced, a write hit also sets modified, and a refill clears both.
- R9: When no entry is free, the refill replaces the entry at a rotating pointer. The pointer starts at entry 0 after reset, advances by one on each eviction and wraps after ENTRIES-1.
- R10: On a hit, `lk_cach` reports the entry's cacheable bit as written by the refill. It is 0 on a miss or a fault.
- R11: After reset every entry is invalid, so any lookup misses, and `lk_done`, `lk_hit` and `lk_fault` are 0 until a lookup is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VPN_W+OFS_W | Virtual address to translate |
| lk_pid | input | PID_W | Current process id |
| lk_write | input | 1 | 1 = write access, 0 = read |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | VPN_W | Page number of the new mapping |
| rf_pid | input | PID_W | Owner process id of the new mapping |
| rf_pfn | input | PFN_W | Frame number of the new mapping |
| rf_wr_ok | input | 1 | Write permission of the new mapping |
| rf_cach | input | 1 | Cacheable bit of the new mapping |
| fl_valid | input | 1 | Flush request |
| fl_all | input | 1 | 1 = flush every entry, 0 = flush entries of `fl_pid` |
| fl_pid | input | PID_W | Process id selected by a partial flush |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Translation found and permitted |
| lk_fault | output | 1 | Write to a page without write permission |
| lk_paddr | output | PFN_W+OFS_W | Physical address |
| lk_cach | output | 1 | Cacheable bit of the hit entry |
| lk_ref_prev | output | 1 | Referenced bit before this access |
| lk_mod_prev | output | 1 | Modified bit before this access |

## Verification
Some rules hold on every cycle and are checked that way: the one-cycle result timing, offset pass-through, hit and fault never reported together, at most one tag match, a full flush emptying the table, and the occupancy change after a refill into a free slot or an overwrite. The bench scenarios are needed for the rest: they show which entry a refill displaces in round-robin order after free slots are used lowest-first, that a per-process flush spares other processes, how the referenced and modified bits evolve over a sequence of reads, writes, faults and refills, and how the untagged variant ignores the id.

// File: rtl/ptag_tlb_pkg.sv
package ptag_tlb_pkg;

   typedef enum logic {
      ACC_READ  = 1'b0,
      ACC_WRITE = 1'b1
   } acc_e;

   // per-entry state kept beside the tag and frame
   typedef struct packed {
      logic valid;
      logic wr_ok;
      logic refd;
      logic mod;
      logic cach;
   } ent_state_t;

endpackage

// File: rtl/ptag_tlb_match.sv
module ptag_tlb_match #(
   parameter int ENTRIES = 64,
   parameter int VPN_W   = 20,
   parameter int PID_W   = 8,
   parameter int PID_EN  = 1,
   parameter int IDX_W   = 6
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [ENTRIES-1:0][VPN_W-1:0]   vpn_tab,
   input  logic [ENTRIES-1:0][PID_W-1:0]   pid_tab,
   input  logic [ENTRIES-1:0]              vld_tab,
   input  logic [VPN_W-1:0]                key_vpn,
   input  logic [PID_W-1:0]                key_pid,
   output logic                            hit_any,
   output logic [IDX_W-1:0]                hit_idx
);

   logic [ENTRIES-1:0] hit_vec;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      if (PID_EN != 0) begin : g_tagged
         assign hit_vec[i] = vld_tab[i] && (vpn_tab[i] == key_vpn)
                             && (pid_tab[i] == key_pid);
      end else begin : g_untagged
         assign hit_vec[i] = vld_tab[i] && (vpn_tab[i] == key_vpn);
      end
   end

   // one-hot to index: OR of the indices of set bits
   always_comb begin
      hit_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
      end
   end

   assign hit_any = |hit_vec;

   // R4: refill placement must never create a duplicate tag
   a_r4_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec))
      else $error("duplicate tag match");

endmodule

// File: rtl/ptag_tlb_victim.sv
module ptag_tlb_victim #(
   parameter int ENTRIES = 64,
   parameter int IDX_W   = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ENTRIES-1:0]  vld_tab,
   input  logic                evict,
   output logic                free_any,
   output logic [IDX_W-1:0]    free_idx,
   output logic [IDX_W-1:0]    rr_ptr
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   // lowest-numbered invalid slot
   always_comb begin
      free_any = 1'b0;
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!vld_tab[i]) begin
            free_any = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rr_ptr <= '0;
      end else if (evict) begin
         rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
      end
   end

   // R9: pointer only moves on an eviction
   a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !evict |=> $stable(rr_ptr))
      else $error("victim pointer moved without eviction");

   // R9: pointer never leaves the entry range
   a_r9_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
      rr_ptr <= LAST)
      else $error("victim pointer out of range");

   // R5: eviction is only requested when no slot is free
   a_r5_evict_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      evict |-> !free_any)
      else $error("eviction while a free slot exists");

endmodule

// File: rtl/ptag_tlb.sv
module ptag_tlb
   import ptag_tlb_pkg::*;
#(
   parameter int ENTRIES = 64,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int OFS_W   = 12,
   parameter int PID_W   = 8,
   parameter int PID_EN  = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     lk_valid,
   input  logic [VPN_W+OFS_W-1:0]   lk_vaddr,
   input  logic [PID_W-1:0]         lk_pid,
   input  logic                     lk_write,
   input  logic                     rf_valid,
   input  logic [VPN_W-1:0]         rf_vpn,
   input  logic [PID_W-1:0]         rf_pid,
   input  logic [PFN_W-1:0]         rf_pfn,
   input  logic                     rf_wr_ok,
   input  logic                     rf_cach,
   input  logic                     fl_valid,
   input  logic                     fl_all,
   input  logic [PID_W-1:0]         fl_pid,
   output logic                     lk_done,
   output logic                     lk_hit,
   output logic                     lk_fault,
   output logic [PFN_W+OFS_W-1:0]   lk_paddr,
   output logic                     lk_cach,
   output logic                     lk_ref_prev,
   output logic                     lk_mod_prev
);

   localparam int VA_W  = VPN_W + OFS_W;
   localparam int PA_W  = PFN_W + OFS_W;
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   // elaboration-time parameter checks
   if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_entries
      $error("ENTRIES must lie in 2..64");
   end
   if (OFS_W < 1 || VPN_W < 1 || PFN_W < 1 || PID_W < 1) begin : g_bad_width
      $error("field widths must be positive");
   end
   if (PID_EN != 0 && PID_EN != 1) begin : g_bad_pid_en
      $error("PID_EN must be 0 or 1");
   end

   // entry storage
   logic [ENTRIES-1:0][VPN_W-1:0] tab_vpn;
   logic [ENTRIES-1:0][PID_W-1:0] tab_pid;
   logic [ENTRIES-1:0][PFN_W-1:0] tab_pfn;
   ent_state_t [ENTRIES-1:0]      tab_st;
   logic [ENTRIES-1:0]            tab_vld;
   logic [ENTRIES-1:0]            flush_vec;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      assign tab_vld[i] = tab_st[i].valid;
      if (PID_EN != 0) begin : g_fl_tag
         assign flush_vec[i] = fl_valid && (fl_all || (tab_pid[i] == fl_pid));
      end else begin : g_fl_all
         assign flush_vec[i] = fl_valid;
      end
   end

   // lookup path
   logic             lk_any;
   logic [IDX_W-1:0] lk_idx;
   ent_state_t       hit_st;
   acc_e             acc;
   logic             perm_bad, good_hit, bad_hit;

   ptag_tlb_match #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W),
      .PID_EN(PID_EN), .IDX_W(IDX_W)
   ) u_lk_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .vpn_tab (tab_vpn),
      .pid_tab (tab_pid),
      .vld_tab (tab_vld),
      .key_vpn (lk_vaddr[VA_W-1:OFS_W]),
      .key_pid (lk_pid),
      .hit_any (lk_any),
      .hit_idx (lk_idx)
   );

   assign acc      = acc_e'(lk_write);
   assign hit_st   = tab_st[lk_idx];
   assign perm_bad = (acc == ACC_WRITE) && !hit_st.wr_ok;
   assign good_hit = lk_valid && lk_any && !perm_bad;
   assign bad_hit  = lk_valid && lk_any && perm_bad;

   // refill path
   logic             rf_any, free_any, evict_go;
   logic [IDX_W-1:0] rf_idx, free_idx, rr_ptr, rf_slot;

   ptag_tlb_match #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W),
      .PID_EN(PID_EN), .IDX_W(IDX_W)
   ) u_rf_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .vpn_tab (tab_vpn),
      .pid_tab (tab_pid),
      .vld_tab (tab_vld),
      .key_vpn (rf_vpn),
      .key_pid (rf_pid),
      .hit_any (rf_any),
      .hit_idx (rf_idx)
   );

   ptag_tlb_victim #(
      .ENTRIES(ENTRIES), .IDX_W(IDX_W)
   ) u_victim (
      .clk      (clk),
      .rst_n    (rst_n),
      .vld_tab  (tab_vld),
      .evict    (evict_go),
      .free_any (free_any),
      .free_idx (free_idx),
      .rr_ptr   (rr_ptr)
   );

   assign evict_go = rf_valid && !rf_any && !free_any;
   assign rf_slot  = rf_any   ? rf_idx   :
                     free_any ? free_idx : rr_ptr;

   // table update: flush, then hit bookkeeping, then refill (last wins)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tab_st  <= '0;
         tab_vpn <= '0;
         tab_pid <= '0;
         tab_pfn <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (flush_vec[i]) tab_st[i].valid <= 1'b0;
         end
         if (good_hit) begin
            tab_st[lk_idx].refd <= 1'b1;
            if (acc == ACC_WRITE) tab_st[lk_idx].mod <= 1'b1;
         end
         if (rf_valid) begin
            tab_vpn[rf_slot] <= rf_vpn;
            tab_pid[rf_slot] <= rf_pid;
            tab_pfn[rf_slot] <= rf_pfn;
            tab_st[rf_slot]  <= '{valid: 1'b1, wr_ok: rf_wr_ok, refd: 1'b0,
                                  mod: 1'b0, cach: rf_cach};
         end
      end
   end

   // registered lookup result
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lk_done     <= 1'b0;
         lk_hit      <= 1'b0;
         lk_fault    <= 1'b0;
         lk_paddr    <= '0;
         lk_cach     <= 1'b0;
         lk_ref_prev <= 1'b0;
         lk_mod_prev <= 1'b0;
      end else begin
         lk_done     <= lk_valid;
         lk_hit      <= good_hit;
         lk_fault    <= bad_hit;
         lk_paddr    <= good_hit ? {tab_pfn[lk_idx], lk_vaddr[OFS_W-1:0]}
                                 : '0;
         lk_cach     <= good_hit && hit_st.cach;
         lk_ref_prev <= good_hit && hit_st.refd;
         lk_mod_prev <= good_hit && hit_st.mod;
      end
   end

   // R1: every request gets its answer on the next cycle
   a_r1_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> lk_done)
      else $error("lookup result missing");

   // R1: no result flags without a request
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_done |-> (!lk_hit && !lk_fault))
      else $error("result flags without lookup");

   // R1: page offset passes through untouched
   a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (lk_paddr[OFS_W-1:0] == $past(lk_vaddr[OFS_W-1:0])))
      else $error("page offset altered");

   // R6: a fault is never also a hit
   a_r6_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_hit && lk_fault))
      else $error("hit and fault together");

   // R7: full flush leaves nothing resident
   a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_valid && (fl_all || (PID_EN == 0)) && !rf_valid) |=> (tab_vld == '0))
      else $error("entries survived a full flush");

   // R5: refill of an absent page into a free slot adds one entry
   a_r5_fill_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_valid && !rf_any && free_any && !fl_valid)
      |=> ($countones(tab_vld) == $past($countones(tab_vld)) + 1))
      else $error("free-slot refill did not add one entry");

   // R4: overwrite of a present page keeps occupancy
   a_r4_overwrite_same: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_valid && rf_any && !fl_valid)
      |=> ($countones(tab_vld) == $past($countones(tab_vld))))
      else $error("in-place refill changed occupancy");

   // R9: with the table full, a new page keeps it full
   a_r9_evict_full: assert property (@(posedge clk) disable iff (!rst_n)
      (evict_go && !fl_valid) |=> (tab_vld == '1))
      else $error("eviction left a hole");

   // PA_W is used only to document the address width
   if (PA_W != PFN_W + OFS_W) begin : g_bad_pa
      $error("physical address width mismatch");
   end

endmodule

// File: tb/ptag_tlb_test.sv
module ptag_tlb_test;

   localparam int VPN_W = 20;
   localparam int PFN_W = 20;
   localparam int OFS_W = 12;
   localparam int PID_W = 8;
   localparam int PA_W  = PFN_W + OFS_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;   // 200 MHz

   // shared stimulus, per-instance strobes
   logic [VPN_W+OFS_W-1:0] lk_vaddr = '0;
   logic [PID_W-1:0]       lk_pid = '0;
   logic                   lk_write = 1'b0;
   logic [VPN_W-1:0]       rf_vpn = '0;
   logic [PID_W-1:0]       rf_pid = '0;
   logic [PFN_W-1:0]       rf_pfn = '0;
   logic                   rf_wr_ok = 1'b0, rf_cach = 1'b0;
   logic                   fl_all = 1'b0;
   logic [PID_W-1:0]       fl_pid = '0;
   logic lk_v0 = 0, lk_v1 = 0, rf_v0 = 0, rf_v1 = 0, fl_v0 = 0, fl_v1 = 0;

   logic            d0, h0, f0, c0, r0, m0;
   logic [PA_W-1:0] p0;
   logic            d1, h1, f1, c1, r1, m1;
   logic [PA_W-1:0] p1;

   ptag_tlb #(.ENTRIES(8), .PID_EN(1)) uut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_v0), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid), .lk_write(lk_write),
      .rf_valid(rf_v0), .rf_vpn(rf_vpn), .rf_pid(rf_pid), .rf_pfn(rf_pfn),
      .rf_wr_ok(rf_wr_ok), .rf_cach(rf_cach),
      .fl_valid(fl_v0), .fl_all(fl_all), .fl_pid(fl_pid),
      .lk_done(d0), .lk_hit(h0), .lk_fault(f0), .lk_paddr(p0),
      .lk_cach(c0), .lk_ref_prev(r0), .lk_mod_prev(m0));

   ptag_tlb #(.ENTRIES(4), .PID_EN(0)) uut_nopid (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_v1), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid), .lk_write(lk_write),
      .rf_valid(rf_v1), .rf_vpn(rf_vpn), .rf_pid(rf_pid), .rf_pfn(rf_pfn),
      .rf_wr_ok(rf_wr_ok), .rf_cach(rf_cach),
      .fl_valid(fl_v1), .fl_all(fl_all), .fl_pid(fl_pid),
      .lk_done(d1), .lk_hit(h1), .lk_fault(f1), .lk_paddr(p1),
      .lk_cach(c1), .lk_ref_prev(r1), .lk_mod_prev(m1));

   typedef struct {
      logic [PA_W+4:0] res;   // {hit, fault, paddr, cach, ref, mod}
      string           tag;
   } exp_t;

   exp_t sb[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   finished = 0;

   // driver: push expectation, pulse the lookup strobe
   task automatic lookup(input bit which, input logic [VPN_W-1:0] vpn,
                         input logic [OFS_W-1:0] ofs, input logic [PID_W-1:0] pid,
                         input logic wr, input logic eh, input logic ef,
                         input logic [PFN_W-1:0] epfn, input logic ec,
                         input logic er, input logic em, input string tag);
      exp_t e;
      logic [PA_W-1:0] ep;
      ep = eh ? {epfn, ofs} : '0;
      e.res = {eh, ef, ep, ec, er, em};
      e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      lk_vaddr = {vpn, ofs};
      lk_pid   = pid;
      lk_write = wr;
      lk_v0 = !which;
      lk_v1 = which;
      @(negedge clk);
      lk_v0 = 1'b0;
      lk_v1 = 1'b0;
   endtask

   task automatic miss(input bit which, input logic [VPN_W-1:0] vpn,
                       input logic [PID_W-1:0] pid, input string tag);
      lookup(which, vpn, 12'h0F0, pid, 1'b0, 0, 0, '0, 0, 0, 0, tag);
   endtask

   task automatic refill(input bit which, input logic [VPN_W-1:0] vpn,
                         input logic [PID_W-1:0] pid, input logic [PFN_W-1:0] pfn,
                         input logic wok, input logic cach);
      @(negedge clk);
      rf_vpn = vpn; rf_pid = pid; rf_pfn = pfn; rf_wr_ok = wok; rf_cach = cach;
      rf_v0 = !which;
      rf_v1 = which;
      @(negedge clk);
      rf_v0 = 1'b0;
      rf_v1 = 1'b0;
   endtask

   task automatic flush(input bit which, input logic all, input logic [PID_W-1:0] pid);
      @(negedge clk);
      fl_all = all; fl_pid = pid;
      fl_v0 = !which;
      fl_v1 = which;
      @(negedge clk);
      fl_v0 = 1'b0;
      fl_v1 = 1'b0;
   endtask

   // monitor: compare results away from the active edge
   always @(negedge clk) begin
      if (!finished && (d0 || d1)) begin
         logic [PA_W+4:0] got;
         exp_t e;
         got = d0 ? {h0, f0, p0, c0, r0, m0} : {h1, f1, p1, c1, r1, m1};
         n_chk++;
         if (sb.size() == 0) begin
            n_fail++;
            $display("FAIL R1 unexpected result: got %h expected none", got);
         end else begin
            e = sb.pop_front();
            if (got !== e.res) begin
               n_fail++;
               $display("FAIL %s: got %h expected %h", e.tag, got, e.res);
            end
         end
      end
   end

   task automatic summary;
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: got hang, expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      n_chk++;
      if ({d0, h0, f0, d1, h1, f1} !== 6'b0) begin
         n_fail++;
         $display("FAIL R11 reset outputs: got %b expected 000000", {d0, h0, f0, d1, h1, f1});
      end
      rst_n = 1'b1;
      miss(0, 20'h00010, 8'd1, "R11 empty after reset");

      // R1 R10 R8 basic translation and state bits
      refill(0, 20'h00010, 8'd1, 20'h0AAAA, 1, 1);
      lookup(0, 20'h00010, 12'h123, 8'd1, 0, 1, 0, 20'h0AAAA, 1, 0, 0, "R1 R10 first read hit");
      lookup(0, 20'h00010, 12'h456, 8'd1, 0, 1, 0, 20'h0AAAA, 1, 1, 0, "R8 referenced set");
      lookup(0, 20'h00010, 12'hFFF, 8'd1, 1, 1, 0, 20'h0AAAA, 1, 1, 0, "R8 write hit");
      lookup(0, 20'h00010, 12'h000, 8'd1, 0, 1, 0, 20'h0AAAA, 1, 1, 1, "R8 modified set");

      // R2 process tagging
      miss(0, 20'h00010, 8'd2, "R2 other pid misses");
      refill(0, 20'h00010, 8'd2, 20'h0BBBB, 0, 0);
      lookup(0, 20'h00010, 12'h321, 8'd2, 0, 1, 0, 20'h0BBBB, 0, 0, 0, "R2 R10 pid2 hit read-only");
      lookup(0, 20'h00010, 12'h321, 8'd1, 0, 1, 0, 20'h0AAAA, 1, 1, 1, "R2 pid1 coexists");

      // R6 write protection
      lookup(0, 20'h00010, 12'h777, 8'd2, 1, 0, 1, '0, 0, 0, 0, "R6 write fault");
      lookup(0, 20'h00010, 12'h777, 8'd2, 0, 1, 0, 20'h0BBBB, 0, 1, 0, "R6 fault left bits");

      // R4 overwrite in place
      refill(0, 20'h00010, 8'd1, 20'h0CCCC, 1, 1);
      lookup(0, 20'h00010, 12'h010, 8'd1, 0, 1, 0, 20'h0CCCC, 1, 0, 0, "R4 R8 overwritten entry");
      lookup(0, 20'h00010, 12'h010, 8'd2, 0, 1, 0, 20'h0BBBB, 0, 1, 0, "R4 neighbour intact");

      // fill slots 2..7, then evict in round-robin order (R9)
      for (int i = 0; i < 6; i++)
         refill(0, 20'h00020 + 20'(i), 8'd3, 20'h00100 + 20'(i), 1, 1);
      refill(0, 20'h00030, 8'd3, 20'h00130, 1, 1);
      miss(0, 20'h00010, 8'd1, "R9 slot0 evicted first");
      lookup(0, 20'h00010, 12'h002, 8'd2, 0, 1, 0, 20'h0BBBB, 0, 1, 0, "R9 slot1 kept");
      refill(0, 20'h00031, 8'd3, 20'h00131, 1, 1);
      miss(0, 20'h00010, 8'd2, "R9 slot1 evicted second");
      lookup(0, 20'h00021, 12'h0AB, 8'd3, 0, 1, 0, 20'h00101, 1, 0, 0, "R9 later slot kept");
      refill(0, 20'h00040, 8'd4, 20'h00140, 1, 1);
      miss(0, 20'h00020, 8'd3, "R9 slot2 evicted third");
      lookup(0, 20'h00021, 12'h0AB, 8'd3, 0, 1, 0, 20'h00101, 1, 1, 0, "R9 slot3 kept");
      lookup(0, 20'h00040, 12'h004, 8'd4, 0, 1, 0, 20'h00140, 1, 0, 0, "R9 new page hit");

      // R7 per-pid flush
      flush(0, 0, 8'd3);
      lookup(0, 20'h00040, 12'h004, 8'd4, 0, 1, 0, 20'h00140, 1, 1, 0, "R7 other pid survives");
      miss(0, 20'h00021, 8'd3, "R7 pid3 flushed");
      miss(0, 20'h00030, 8'd3, "R7 pid3 flushed slot0");

      // R5 free slots first, lowest index, then rotation resumes at 3
      for (int k = 0; k < 7; k++)
         refill(0, 20'h00050 + 20'(k), 8'd5, 20'h00150 + 20'(k), 1, 1);
      lookup(0, 20'h00040, 12'h004, 8'd4, 0, 1, 0, 20'h00140, 1, 1, 0, "R5 no eviction while free");
      refill(0, 20'h00060, 8'd5, 20'h00160, 1, 1);
      miss(0, 20'h00052, 8'd5, "R5 R9 third free fill went to slot3");
      lookup(0, 20'h00050, 12'h111, 8'd5, 0, 1, 0, 20'h00150, 1, 0, 0, "R5 slot0 fill kept");
      lookup(0, 20'h00053, 12'h111, 8'd5, 0, 1, 0, 20'h00153, 1, 0, 0, "R5 slot4 fill kept");
      lookup(0, 20'h00040, 12'h111, 8'd4, 0, 1, 0, 20'h00140, 1, 1, 0, "R9 slot2 kept");
      lookup(0, 20'h00060, 12'h222, 8'd5, 0, 1, 0, 20'h00160, 1, 0, 0, "R9 replacement hit");

      // R7 full flush
      flush(0, 1, 8'd0);
      miss(0, 20'h00040, 8'd4, "R7 full flush pid4");
      miss(0, 20'h00060, 8'd5, "R7 full flush pid5");

      // R3 untagged variant
      refill(1, 20'h00007, 8'd1, 20'h00077, 1, 1);
      lookup(1, 20'h00007, 12'h00C, 8'd9, 0, 1, 0, 20'h00077, 1, 0, 0, "R3 pid ignored on match");
      refill(1, 20'h00007, 8'd2, 20'h00088, 1, 0);
      lookup(1, 20'h00007, 12'h00C, 8'd1, 0, 1, 0, 20'h00088, 0, 0, 0, "R3 R4 refill overwrote");
      flush(1, 0, 8'd5);
      miss(1, 20'h00007, 8'd1, "R3 any flush clears all");

      repeat (3) @(negedge clk);
      n_chk++;
      if (sb.size() != 0) begin
         n_fail++;
         $display("FAIL R1 pending results: got %0d expected 0", sb.size());
      end
      summary();
   end

endmodule